// File: doc/BRIEF.md
# Longest-Prefix-Match Route Table

This block is an on-chip forwarding table for IPv4 routing with classless prefixes. It holds up to 512 routes. Each lookup presents a destination address, a DSCP byte, an ingress interface number and a two-bit class field. The table returns the route whose prefix is longest among all matching entries. Each route carries a next-hop address, an 8-bit network number and a 32-bit egress tag.

A route can also require a specific DSCP value, a specific ingress interface, or both. This lets QoS policy steer traffic to different next hops for the same destination. Lookups are fully pipelined: one can be issued on every clock, and each result appears exactly three clocks later.

A host write port installs or invalidates one entry per cycle. A zero-length prefix acts as a default gateway. This lets control software keep its full routing database elsewhere and use the table as a cache of active routes.

Top module: `lpm_route_table`

## Requirements
- R1: After reset every entry is invalid, `res_valid_o` and `res_hit_o` are low, and all response fields are zero.
- R2: When several entries match a lookup, the result is the one with the greatest prefix length.
- R3: Address bits of an entry beyond its prefix length are ignored when comparing. An entry of length 0 matches every address and so serves as a default route.
- R4: A lookup sampled with `lk_valid_i` high on clock edge k produces `res_valid_o` high after edge k+2, and low after edges k and k+1 if no other lookup is in flight. Lookups may be issued on consecutive edges, and their results come out in the same order.
- R5: A lookup that matches no entry returns `res_hit_o` low, and next hop, network and tag all zero.
- R6: An entry whose DSCP wildcard bit is 0 matches only lookups with an equal 8-bit DSCP value. With the wildcard bit set, DSCP is ignored.
- R7: An entry whose interface wildcard bit is 0 matches only lookups with an equal 7-bit interface ID. With the wildcard bit set, the interface is ignored.
- R8: Among matches of equal prefix length, the one with more qualified (non-wildcard) fields wins. If still equal, the lower entry index wins.
- R9: The 2-bit class field of a lookup must equal the entry's class field exactly for a match.
- R10: A write with `wr_valid_i` low makes the addressed entry stop matching.
- R11: A write sampled on edge w is seen by a lookup sampled on edge w+1.
- R12: A written prefix length above 32 is stored as 32, so the entry is an exact host route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_idx_i | input | 9 | Entry index written |
| wr_valid_i | input | 1 | 1 installs the entry, 0 invalidates it |
| wr_plen_i | input | 6 | Prefix length, 0 to 32 (larger saturates) |
| wr_ip_i | input | 32 | Route prefix address |
| wr_dscp_i | input | 8 | DSCP qualifier value |
| wr_dscp_any_i | input | 1 | 1 = ignore DSCP |
| wr_if_i | input | 7 | Ingress interface qualifier |
| wr_if_any_i | input | 1 | 1 = ignore interface |
| wr_ctrl_i | input | 2 | Class field, exact match |
| wr_nh_i | input | 32 | Next-hop address to return |
| wr_net_i | input | 8 | Network number to return |
| wr_tag_i | input | 32 | Egress tag to return |
| lk_valid_i | input | 1 | Lookup issue strobe |
| lk_ip_i | input | 32 | Destination address |
| lk_dscp_i | input | 8 | Packet DSCP byte |
| lk_if_i | input | 7 | Ingress interface ID |
| lk_ctrl_i | input | 2 | Lookup class field |
| res_valid_o | output | 1 | Result valid, three clocks after issue |
| res_hit_o | output | 1 | A matching entry was found |
| res_nh_o | output | 32 | Next-hop address of the winner |
| res_net_o | output | 8 | Network number of the winner |
| res_tag_o | output | 32 | Egress tag of the winner |

## Verification
The hardest outcomes to observe are the ones where several entries match at once and only the ordering rule separates them. Examples are two routes of equal length where one is DSCP-qualified, two identical wildcard routes at neighbouring indices, and nested /8, /16 and /24 prefixes in the presence of a default route. The stimulus installs these overlapping sets on purpose and checks the winner by its tag, which encodes the entry index. A write is followed on the very next clock by a lookup to reach the earliest visibility point. Three lookups are also issued on back-to-back clocks to expose ordering and latency in the pipeline.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IP_W    = 32;
  localparam int DSCP_W  = 8;
  localparam int IF_W    = 7;
  localparam int CTRL_W  = 2;
  localparam int PLEN_W  = 6;
  localparam int NH_W    = 32;
  localparam int NET_W   = 8;
  localparam int TAG_W   = 32;
  localparam int QUAL_W  = 2;
  localparam int SCORE_W = PLEN_W + QUAL_W;

  typedef struct packed {
    logic [IP_W-1:0]   ip;
    logic [PLEN_W-1:0] plen;
    logic [DSCP_W-1:0] dscp;
    logic              dscp_any;
    logic [IF_W-1:0]   ifid;
    logic              if_any;
    logic [CTRL_W-1:0] ctrl;
  } rule_t;

  typedef struct packed {
    logic [NH_W-1:0]  nh;
    logic [NET_W-1:0] net;
    logic [TAG_W-1:0] tag;
  } resp_t;

  function automatic logic [IP_W-1:0] prefix_mask(input logic [PLEN_W-1:0] plen);
    logic [IP_W-1:0] ones;
    ones = '1;
    if (plen == '0) return '0;
    return ones << (PLEN_W'(IP_W) - plen);
  endfunction
endpackage

// File: rtl/lpm_entry_match.sv
module lpm_entry_match
  import lpm_pkg::*;
(
  input  logic                vld_i,
  input  rule_t               rule_i,
  input  logic [IP_W-1:0]     ip_i,
  input  logic [DSCP_W-1:0]   dscp_i,
  input  logic [IF_W-1:0]     if_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  output logic                hit_o,
  output logic [SCORE_W-1:0]  score_o
);
  logic ip_ok, dscp_ok, if_ok, ctrl_ok;
  logic [QUAL_W-1:0] nqual;

  always_comb begin
    ip_ok   = ((ip_i ^ rule_i.ip) & prefix_mask(rule_i.plen)) == '0;
    dscp_ok = rule_i.dscp_any || (dscp_i == rule_i.dscp);
    if_ok   = rule_i.if_any || (if_i == rule_i.ifid);
    ctrl_ok = ctrl_i == rule_i.ctrl;
    hit_o   = vld_i && ip_ok && dscp_ok && if_ok && ctrl_ok;
    // qualified fields break ties between equal prefix lengths
    nqual   = {1'b0, ~rule_i.dscp_any} + {1'b0, ~rule_i.if_any};
    score_o = {rule_i.plen, nqual};
  end
endmodule

// File: rtl/lpm_rule_store.sv
module lpm_rule_store
  import lpm_pkg::*;
#(
  parameter int N  = 512,
  parameter int IW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_valid_i,
  input  rule_t         wr_rule_i,
  input  resp_t         wr_resp_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [N-1:0]  vld_o,
  output rule_t         rules_o [N],
  output resp_t         rd_resp_o
);
  rule_t rule_q [N];
  resp_t resp_q [N];
  rule_t wr_rule_sat;
  logic  wr_hit;

  always_comb begin
    wr_rule_sat = wr_rule_i;
    if (wr_rule_i.plen > PLEN_W'(IP_W)) wr_rule_sat.plen = PLEN_W'(IP_W);
    wr_hit = wr_en_i && (int'(wr_idx_i) < N);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= '0;
    else if (wr_hit) vld_o[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_hit) begin
      rule_q[wr_idx_i] <= wr_rule_sat;
      resp_q[wr_idx_i] <= wr_resp_i;
    end
  end

  assign rules_o   = rule_q;
  assign rd_resp_o = resp_q[rd_idx_i];
endmodule

// File: rtl/lpm_best_select.sv
module lpm_best_select #(
  parameter int N  = 512,
  parameter int IW = 9,
  parameter int SW = 8
) (
  input  logic [N-1:0]         match_i,
  input  logic [N-1:0][SW-1:0] score_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  localparam int LVL = (N > 1) ? $clog2(N) : 1;
  localparam int NP  = 1 << LVL;

  // balanced tree; left (lower index) wins on equal score
  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int W = NP >> l;
    logic [W-1:0]         h;
    logic [W-1:0][SW-1:0] s;
    logic [W-1:0][IW-1:0] x;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_j
        if (j < N) begin : g_real
          assign h[j] = match_i[j];
          assign s[j] = score_i[j];
          assign x[j] = IW'(j);
        end else begin : g_pad
          assign h[j] = 1'b0;
          assign s[j] = '0;
          assign x[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_j
        logic lw;
        assign lw = g_lvl[l-1].h[2*j] &&
                    (!g_lvl[l-1].h[2*j+1] || (g_lvl[l-1].s[2*j] >= g_lvl[l-1].s[2*j+1]));
        assign h[j] = g_lvl[l-1].h[2*j] | g_lvl[l-1].h[2*j+1];
        assign s[j] = lw ? g_lvl[l-1].s[2*j] : g_lvl[l-1].s[2*j+1];
        assign x[j] = lw ? g_lvl[l-1].x[2*j] : g_lvl[l-1].x[2*j+1];
      end
    end
  end

  assign hit_o = g_lvl[LVL].h[0];
  assign idx_o = g_lvl[LVL].x[0];
endmodule

// File: rtl/lpm_route_table.sv
module lpm_route_table
  import lpm_pkg::*;
#(
  parameter  int N_ENTRIES = 512,
  localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [PLEN_W-1:0] wr_plen_i,
  input  logic [IP_W-1:0]   wr_ip_i,
  input  logic [DSCP_W-1:0] wr_dscp_i,
  input  logic              wr_dscp_any_i,
  input  logic [IF_W-1:0]   wr_if_i,
  input  logic              wr_if_any_i,
  input  logic [CTRL_W-1:0] wr_ctrl_i,
  input  logic [NH_W-1:0]   wr_nh_i,
  input  logic [NET_W-1:0]  wr_net_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              lk_valid_i,
  input  logic [IP_W-1:0]   lk_ip_i,
  input  logic [DSCP_W-1:0] lk_dscp_i,
  input  logic [IF_W-1:0]   lk_if_i,
  input  logic [CTRL_W-1:0] lk_ctrl_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [NH_W-1:0]   res_nh_o,
  output logic [NET_W-1:0]  res_net_o,
  output logic [TAG_W-1:0]  res_tag_o
);
  rule_t               wr_rule;
  resp_t               wr_resp;
  logic [N_ENTRIES-1:0] ent_vld;
  rule_t               ent_rule [N_ENTRIES];
  resp_t               rd_resp;

  logic [N_ENTRIES-1:0]              cmp_hit;
  logic [N_ENTRIES-1:0][SCORE_W-1:0] cmp_score;

  logic                              s1_valid;
  logic [N_ENTRIES-1:0]              s1_match;
  logic [N_ENTRIES-1:0][SCORE_W-1:0] s1_score;

  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic             s2_valid, s2_hit;
  logic [IDX_W-1:0] s2_idx;

  always_comb begin
    wr_rule.ip       = wr_ip_i;
    wr_rule.plen     = wr_plen_i;
    wr_rule.dscp     = wr_dscp_i;
    wr_rule.dscp_any = wr_dscp_any_i;
    wr_rule.ifid     = wr_if_i;
    wr_rule.if_any   = wr_if_any_i;
    wr_rule.ctrl     = wr_ctrl_i;
    wr_resp.nh       = wr_nh_i;
    wr_resp.net      = wr_net_i;
    wr_resp.tag      = wr_tag_i;
  end

  lpm_rule_store #(.N(N_ENTRIES), .IW(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_rule_i  (wr_rule),
    .wr_resp_i  (wr_resp),
    .rd_idx_i   (s2_idx),
    .vld_o      (ent_vld),
    .rules_o    (ent_rule),
    .rd_resp_o  (rd_resp)
  );

  // stage 1: compare key against every entry
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    lpm_entry_match u_match (
      .vld_i   (ent_vld[e]),
      .rule_i  (ent_rule[e]),
      .ip_i    (lk_ip_i),
      .dscp_i  (lk_dscp_i),
      .if_i    (lk_if_i),
      .ctrl_i  (lk_ctrl_i),
      .hit_o   (cmp_hit[e]),
      .score_o (cmp_score[e])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_match <= '0;
    end else begin
      s1_valid <= lk_valid_i;
      s1_match <= lk_valid_i ? cmp_hit : '0;
    end
  end

  always_ff @(posedge clk_i) s1_score <= cmp_score;

  // stage 2: reduce to the best score
  lpm_best_select #(.N(N_ENTRIES), .IW(IDX_W), .SW(SCORE_W)) u_sel (
    .match_i (s1_match),
    .score_i (s1_score),
    .hit_o   (sel_hit),
    .idx_o   (sel_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_hit   <= 1'b0;
      s2_idx   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_hit   <= s1_valid && sel_hit;
      s2_idx   <= sel_idx;
    end
  end

  // stage 3: fetch response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_nh_o    <= '0;
      res_net_o   <= '0;
      res_tag_o   <= '0;
    end else begin
      res_valid_o <= s2_valid;
      res_hit_o   <= s2_hit;
      res_nh_o    <= s2_hit ? rd_resp.nh  : '0;
      res_net_o   <= s2_hit ? rd_resp.net : '0;
      res_tag_o   <= s2_hit ? rd_resp.tag : '0;
    end
  end
endmodule

// File: rtl/lpm_route_table_chk.sv
module lpm_route_table_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lk_valid_i,
  input logic        res_valid_o,
  input logic        res_hit_o,
  input logic [31:0] res_nh_o,
  input logic [7:0]  res_net_o,
  input logic [31:0] res_tag_o,
  input logic        s1_any_i,
  input logic        ent_any_i
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r4_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (res_valid_o == $past(lk_valid_i, 3)));

  a_r5_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);

  a_r5_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_nh_o == '0 && res_net_o == '0 && res_tag_o == '0));

  a_r10_match_needs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && s1_any_i) |-> $past(ent_any_i));
endmodule

bind lpm_route_table lpm_route_table_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .res_valid_o (res_valid_o),
  .res_hit_o   (res_hit_o),
  .res_nh_o    (res_nh_o),
  .res_net_o   (res_net_o),
  .res_tag_o   (res_tag_o),
  .s1_any_i    (|s1_match),
  .ent_any_i   (|ent_vld)
);

// File: tb/lpm_route_table_test.sv
`timescale 1ns/1ps
module lpm_route_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_dscp_any = 1'b0, wr_if_any = 1'b0;
  logic [8:0]  wr_idx = '0;
  logic [5:0]  wr_plen = '0;
  logic [31:0] wr_ip = '0, wr_nh = '0, wr_tag = '0;
  logic [7:0]  wr_dscp = '0, wr_net = '0;
  logic [6:0]  wr_if = '0;
  logic [1:0]  wr_ctrl = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ip = '0;
  logic [7:0]  lk_dscp = '0;
  logic [6:0]  lk_if = '0;
  logic [1:0]  lk_ctrl = '0;
  logic        res_valid, res_hit;
  logic [31:0] res_nh, res_tag;
  logic [7:0]  res_net;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lpm_route_table uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_plen_i(wr_plen),
    .wr_ip_i(wr_ip), .wr_dscp_i(wr_dscp), .wr_dscp_any_i(wr_dscp_any), .wr_if_i(wr_if),
    .wr_if_any_i(wr_if_any), .wr_ctrl_i(wr_ctrl), .wr_nh_i(wr_nh), .wr_net_i(wr_net),
    .wr_tag_i(wr_tag), .lk_valid_i(lk_valid), .lk_ip_i(lk_ip), .lk_dscp_i(lk_dscp),
    .lk_if_i(lk_if), .lk_ctrl_i(lk_ctrl), .res_valid_o(res_valid), .res_hit_o(res_hit),
    .res_nh_o(res_nh), .res_net_o(res_net), .res_tag_o(res_tag)
  );

  task automatic check(input string req, input logic [72:0] act, input logic [72:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // exp_idx < 0 means miss; response fields encode the entry index
  task automatic check_result(input string req, input int exp_idx);
    logic [72:0] act, exp;
    act = {res_hit, res_nh, res_net, res_tag};
    if (exp_idx < 0) exp = '0;
    else exp = {1'b1, 32'h0A00_0000 + 32'(exp_idx), 8'(exp_idx), 32'hA000_0000 + 32'(exp_idx)};
    check({req, " valid"}, 73'(res_valid), 73'(1));
    check(req, act, exp);
  endtask

  // entered and left at a negedge
  task automatic wr_entry(input int idx, input bit vld, input int plen, input logic [31:0] ip,
                          input logic [7:0] dscp, input bit dany, input logic [6:0] ifid,
                          input bit iany, input logic [1:0] ctrl);
    wr_en = 1'b1; wr_idx = 9'(idx); wr_valid = vld; wr_plen = 6'(plen); wr_ip = ip;
    wr_dscp = dscp; wr_dscp_any = dany; wr_if = ifid; wr_if_any = iany; wr_ctrl = ctrl;
    wr_nh = 32'h0A00_0000 + 32'(idx); wr_net = 8'(idx); wr_tag = 32'hA000_0000 + 32'(idx);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_route(input int idx, input int plen, input logic [31:0] ip);
    wr_entry(idx, 1'b1, plen, ip, 8'h0, 1'b1, 7'h0, 1'b1, 2'd0);
  endtask

  task automatic lookup(input logic [31:0] ip, input logic [7:0] dscp,
                        input logic [6:0] ifid, input logic [1:0] ctrl);
    lk_valid = 1'b1; lk_ip = ip; lk_dscp = dscp; lk_if = ifid; lk_ctrl = ctrl;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset valid", 73'(res_valid), 73'(0));
    check("R1 reset result", {res_hit, res_nh, res_net, res_tag}, '0);
    lookup(32'h0A01_0207, 8'h0, 7'h0, 2'd0);
    check_result("R1 empty table miss", -1);
  endtask

  task automatic t_longest;
    wr_route(5, 8,  32'h0A00_0000);
    wr_route(9, 16, 32'h0A01_0000);
    wr_route(3, 24, 32'h0A01_0263);  // host bits set: R3
    lookup(32'h0A01_0207, 8'h0, 7'h0, 2'd0); check_result("R2 /24 wins, R3 host bits ignored", 3);
    lookup(32'h0A01_0909, 8'h0, 7'h0, 2'd0); check_result("R2 /16 wins", 9);
    lookup(32'h0AC8_0001, 8'h0, 7'h0, 2'd0); check_result("R2 /8 only", 5);
  endtask

  task automatic t_miss;
    lookup(32'h0B00_0001, 8'h0, 7'h0, 2'd0); check_result("R5 miss zero fields", -1);
  endtask

  task automatic t_default;
    wr_route(511, 0, 32'hDEAD_BEEF);
    lookup(32'h0B00_0001, 8'h0, 7'h0, 2'd0); check_result("R3 default route", 511);
    lookup(32'h0A01_0207, 8'h0, 7'h0, 2'd0); check_result("R3 longer beats default", 3);
  endtask

  task automatic t_dscp;
    wr_entry(60, 1'b1, 8, 32'h3200_0000, 8'd46, 1'b0, 7'h0, 1'b1, 2'd0);
    lookup(32'h3201_0101, 8'd46, 7'h0, 2'd0); check_result("R6 dscp equal", 60);
    lookup(32'h3201_0101, 8'd0, 7'h0, 2'd0);  check_result("R6 dscp differs", 511);
  endtask

  task automatic t_intf;
    wr_entry(61, 1'b1, 8, 32'h3C00_0000, 8'h0, 1'b1, 7'd5, 1'b0, 2'd0);
    lookup(32'h3C00_0001, 8'h0, 7'd5, 2'd0); check_result("R7 interface equal", 61);
    lookup(32'h3C00_0001, 8'h0, 7'd6, 2'd0); check_result("R7 interface differs", 511);
  endtask

  task automatic t_tie;
    wr_route(20, 8, 32'h4600_0000);
    wr_entry(30, 1'b1, 8, 32'h4600_0000, 8'd46, 1'b0, 7'h0, 1'b1, 2'd0);
    lookup(32'h4600_0001, 8'd46, 7'h0, 2'd0); check_result("R8 qualified beats wildcard", 30);
    lookup(32'h4600_0001, 8'd1, 7'h0, 2'd0);  check_result("R8 wildcard when qualifier fails", 20);
    wr_route(41, 8, 32'h5000_0000);
    wr_route(40, 8, 32'h5000_0000);
    lookup(32'h5000_0001, 8'h0, 7'h0, 2'd0);  check_result("R8 lower index wins", 40);
  endtask

  task automatic t_ctrl;
    wr_entry(50, 1'b1, 8, 32'h5A00_0000, 8'h0, 1'b1, 7'h0, 1'b1, 2'd2);
    lookup(32'h5A00_0001, 8'h0, 7'h0, 2'd2); check_result("R9 class equal", 50);
    lookup(32'h5A00_0001, 8'h0, 7'h0, 2'd1); check_result("R9 class differs", -1);
  endtask

  task automatic t_invalidate;
    wr_entry(3, 1'b0, 24, 32'h0A01_0200, 8'h0, 1'b1, 7'h0, 1'b1, 2'd0);
    lookup(32'h0A01_0207, 8'h0, 7'h0, 2'd0); check_result("R10 invalidated entry skipped", 9);
  endtask

  task automatic t_next_cycle;
    wr_route(100, 8, 32'h6400_0000);
    lookup(32'h6400_0001, 8'h0, 7'h0, 2'd0); check_result("R11 write seen next cycle", 100);
  endtask

  task automatic t_plen_sat;
    wr_entry(101, 1'b1, 40, 32'h0102_0304, 8'h0, 1'b1, 7'h0, 1'b1, 2'd0);
    lookup(32'h0102_0304, 8'h0, 7'h0, 2'd0); check_result("R12 host route hit", 101);
    lookup(32'h0102_0305, 8'h0, 7'h0, 2'd0); check_result("R12 neighbour misses host route", 511);
  endtask

  task automatic t_back_to_back;
    lk_valid = 1'b1; lk_ip = 32'h0A01_0909; lk_dscp = 8'h0; lk_if = 7'h0; lk_ctrl = 2'd0;
    @(posedge clk); @(negedge clk);
    check("R4 not valid after one edge", 73'(res_valid), 73'(0));
    lk_ip = 32'h0B00_0001;
    @(posedge clk); @(negedge clk);
    check("R4 not valid after two edges", 73'(res_valid), 73'(0));
    lk_ip = 32'h3201_0101; lk_dscp = 8'd46;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    check_result("R4 first of three", 9);
    @(posedge clk); @(negedge clk);
    check_result("R4 second of three", 511);
    @(posedge clk); @(negedge clk);
    check_result("R4 third of three", 60);
    @(posedge clk); @(negedge clk);
    check("R4 valid drops after burst", 73'(res_valid), 73'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_longest();
    t_miss();
    t_default();
    t_dscp();
    t_intf();
    t_tie();
    t_ctrl();
    t_invalidate();
    t_next_cycle();
    t_plen_sat();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule